// File: doc/BRIEF.md
# Shared Timer Prescaler with Synchronized Restart

This block divides the system clock for two timer channels that share one free-running 10-bit divider. Each channel has a 3-bit select that picks where its count-enable comes from. The choices are: no enable, an enable on every cycle, a single-cycle pulse once every 8, 64, 256 or 1024 cycles, or one pulse per edge seen on that channel's external pin after resynchronization. The block produces count enables only, never derived clocks, so every timer stays in the system clock domain.

A small control register restarts the shared divider. Writing its restart bit clears the divider, and hardware drops the bit again after one cycle. If the hold bit is set, the restart bit stays latched instead. While it is latched, every channel enable is forced low, including the undivided one. Software can then program both timers while nothing advances. Clearing the hold bit drops both restart bits, and the channels resume from a common divider value of zero. A second restart bit behaves in the same way but only drives an output, which is meant for a neighbouring prescaler; it does not touch this divider.

Top module: `tmr_presc_share`

## Requirements
- R1: After reset the control register reads 0x00 and the divider holds zero, so the first divided pulse comes after exactly N cycles.
- R2: Select value 0 keeps that channel's enable low.
- R3: Select value 1 keeps that channel's enable high on every cycle in which the divider is not held in restart.
- R4: Select values 2, 3, 4 and 5 give a one-cycle enable once every 8, 64, 256 and 1024 cycles. The enable is high on the cycle in which the divider's low 3, 6, 8 or 10 bits are all ones.
- R5: Select value 7 gives one enable cycle per rising edge of the channel's pin, and value 6 gives one per falling edge. The enable appears in the cycle after the second clock edge that samples the new pin level.
- R6: Writing bit 0 as one while bit 7 is zero clears the divider. Bit 0 then reads one for exactly one cycle, and all enables are low during that cycle.
- R7: While bit 7 is one, a written bit 0 stays one, and every channel enable (undivided, divided and external) stays low.
- R8: A write that leaves bit 7 at zero ends a hold. Both restart bits clear one cycle after that write, and the divider resumes from zero for both channels together.
- R9: Bits 6 down to 2 always read zero, and writes to them have no effect.
- R10: Bit 1 is stored, held and self-cleared in the same way as bit 0, and it drives `aux_rst_o`. It neither clears the divider nor gates any enable.
- R11: Two channels with the same divided or undivided select assert their enables in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data: bit 7 hold, bit 1 auxiliary restart, bit 0 restart |
| reg_rdata | output | 8 | Current control register value |
| clk_sel_i | input | NUM_CH x 3 | Per-channel enable source select |
| ext_pin_i | input | NUM_CH | Per-channel external count pins |
| cnt_en_o | output | NUM_CH | Per-channel count enables |
| aux_rst_o | output | 1 | Level of the auxiliary restart bit |

## Verification
A divider that is off by a few counts does not show up at once. It appears as a pulse in the wrong cycle, at the next all-ones point of the selected tap. That point is at most 8 cycles away with the smallest tap and up to 1024 cycles away with the largest, so every select is run for more than one full divider period. A restart or hold bit in the wrong state shows up on the register read-back in the cycle after the write. The same fault also appears as enables that go low or stay high when they should not. A synchronizer that has the wrong depth moves each pin-driven pulse by one cycle per extra or missing stage.

// File: rtl/presc_pkg.sv
package presc_pkg;

    localparam int CS_W     = 3;
    localparam int NUM_TAPS = 4;
    localparam int REG_W    = 8;

    localparam int BIT_SYNC = 7;
    localparam int BIT_AUX  = 1;
    localparam int BIT_MAIN = 0;

    localparam logic [REG_W-1:0] WRITABLE_MASK =
        REG_W'((1 << BIT_SYNC) | (1 << BIT_AUX) | (1 << BIT_MAIN));

    typedef enum logic [CS_W-1:0] {
        CS_STOP     = 3'd0,
        CS_DIRECT   = 3'd1,
        CS_DIV8     = 3'd2,
        CS_DIV64    = 3'd3,
        CS_DIV256   = 3'd4,
        CS_DIV1024  = 3'd5,
        CS_EXT_FALL = 3'd6,
        CS_EXT_RISE = 3'd7
    } clk_sel_e;

    typedef struct packed {
        logic sync_mode;
        logic aux_rst;
        logic main_rst;
    } ctrl_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } pin_edge_t;

    // log2 of the division ratio of each tap
    function automatic int tap_exp(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_state_t s);
        logic [REG_W-1:0] v;
        v           = '0;
        v[BIT_SYNC] = s.sync_mode;
        v[BIT_AUX]  = s.aux_rst;
        v[BIT_MAIN] = s.main_rst;
        return v;
    endfunction

endpackage

// File: rtl/presc_ctrl_reg.sv
module presc_ctrl_reg
    import presc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output ctrl_state_t      state_o,
    output logic [REG_W-1:0] rdata_o
);

    ctrl_state_t      st_q;
    ctrl_state_t      st_d;
    logic [REG_W-1:0] wr_masked;

    assign wr_masked = wdata & WRITABLE_MASK;

    // a write has priority; otherwise restart bits drop unless held
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.sync_mode = wr_masked[BIT_SYNC];
            st_d.aux_rst   = wr_masked[BIT_AUX];
            st_d.main_rst  = wr_masked[BIT_MAIN];
        end else if (!st_q.sync_mode) begin
            st_d.aux_rst  = 1'b0;
            st_d.main_rst = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;
    assign rdata_o = pack_ctrl(st_q);

endmodule

// File: rtl/presc_counter.sv
module presc_counter
    import presc_pkg::*;
#(
    parameter int PRESC_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    output logic [NUM_TAPS-1:0] tap_tick_o
);

    logic [PRESC_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PRESC_W'(1);
        end
    end

    // one-cycle tick when the low bits of a tap are all ones
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int E = tap_exp(g);
        assign tap_tick_o[g] = !clear && (&cnt_q[E-1:0]);
    end

endmodule

// File: rtl/presc_ext_sync.sv
module presc_ext_sync
    import presc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    output pin_edge_t edge_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign edge_o.rise = sync_q[STAGES-1] && !prev_q;
    assign edge_o.fall = !sync_q[STAGES-1] && prev_q;

endmodule

// File: rtl/presc_chan_sel.sv
module presc_chan_sel
    import presc_pkg::*;
(
    input  clk_sel_e            sel,
    input  logic                halt,
    input  logic [NUM_TAPS-1:0] taps,
    input  pin_edge_t           edg,
    output logic                en_o
);

    logic raw_en;

    always_comb begin
        raw_en = 1'b0;
        case (sel)
            CS_STOP:     raw_en = 1'b0;
            CS_DIRECT:   raw_en = 1'b1;
            CS_DIV8:     raw_en = taps[0];
            CS_DIV64:    raw_en = taps[1];
            CS_DIV256:   raw_en = taps[2];
            CS_DIV1024:  raw_en = taps[3];
            CS_EXT_FALL: raw_en = edg.fall;
            CS_EXT_RISE: raw_en = edg.rise;
            default:     raw_en = 1'b0;
        endcase
    end

    assign en_o = raw_en && !halt;

endmodule

// File: rtl/tmr_presc_share.sv
module tmr_presc_share
    import presc_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int PRESC_W     = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         reg_wr_en,
    input  logic [REG_W-1:0]             reg_wdata,
    output logic [REG_W-1:0]             reg_rdata,
    input  logic [NUM_CH-1:0][CS_W-1:0]  clk_sel_i,
    input  logic [NUM_CH-1:0]            ext_pin_i,
    output logic [NUM_CH-1:0]            cnt_en_o,
    output logic                         aux_rst_o
);

    ctrl_state_t         ctrl;
    logic [NUM_TAPS-1:0] tap_tick;
    logic                halt;

    presc_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wdata   (reg_wdata),
        .state_o (ctrl),
        .rdata_o (reg_rdata)
    );

    assign halt      = ctrl.main_rst;
    assign aux_rst_o = ctrl.aux_rst;

    presc_counter #(.PRESC_W(PRESC_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .clear      (halt),
        .tap_tick_o (tap_tick)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pin_edge_t pin_edge;

        presc_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (ext_pin_i[c]),
            .edge_o (pin_edge)
        );

        presc_chan_sel u_sel (
            .sel  (clk_sel_e'(clk_sel_i[c])),
            .halt (halt),
            .taps (tap_tick),
            .edg  (pin_edge),
            .en_o (cnt_en_o[c])
        );
    end

endmodule

// File: rtl/presc_chk.sv
module presc_chk
    import presc_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        reg_wr_en,
    input logic [REG_W-1:0]            reg_rdata,
    input logic [NUM_CH-1:0][CS_W-1:0] clk_sel_i,
    input logic [NUM_CH-1:0]           cnt_en_o,
    input logic                        aux_rst_o
);

    assert_halt_all_R7: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[BIT_MAIN] |-> (cnt_en_o == '0));

    assert_self_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[BIT_MAIN] && !reg_rdata[BIT_SYNC] && !reg_wr_en) |=> !reg_rdata[BIT_MAIN]);

    assert_hold_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[BIT_MAIN] && reg_rdata[BIT_SYNC] && !reg_wr_en) |=> reg_rdata[BIT_MAIN]);

    assert_aux_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (aux_rst_o && !reg_rdata[BIT_SYNC] && !reg_wr_en) |=> !aux_rst_o);

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[6:2] == '0);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_stop_idle_R2: assert property (@(posedge clk) disable iff (rst)
            (clk_sel_i[c] == CS_STOP) |-> !cnt_en_o[c]);

        assert_direct_on_R3: assert property (@(posedge clk) disable iff (rst)
            (clk_sel_i[c] == CS_DIRECT && !reg_rdata[BIT_MAIN]) |-> cnt_en_o[c]);

        assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
            (cnt_en_o[c] && clk_sel_i[c] >= CS_DIV8)
            |=> (!cnt_en_o[c] || clk_sel_i[c] != $past(clk_sel_i[c])));
    end

    if (NUM_CH > 1) begin : g_pair
        assert_lockstep_R11: assert property (@(posedge clk) disable iff (rst)
            (clk_sel_i[0] == clk_sel_i[1] && clk_sel_i[0] != CS_STOP && clk_sel_i[0] < CS_EXT_FALL)
            |-> (cnt_en_o[0] == cnt_en_o[1]));
    end

endmodule

bind tmr_presc_share presc_chk #(.NUM_CH(NUM_CH)) u_presc_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr_en (reg_wr_en),
    .reg_rdata (reg_rdata),
    .clk_sel_i (clk_sel_i),
    .cnt_en_o  (cnt_en_o),
    .aux_rst_o (aux_rst_o)
);

// File: tb/test_tmr_presc_share.sv
module test_tmr_presc_share;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            reg_wr_en = 1'b0;
    logic [7:0]      reg_wdata = 8'h00;
    logic [7:0]      reg_rdata;
    logic [1:0][2:0] clk_sel = '0;
    logic [1:0]      ext_pin = '0;
    logic [1:0]      cnt_en;
    logic            aux_rst;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string tag_ovr = "";

    // bench-side expectation state
    logic       m_sync = 1'b0;
    logic       m_aux = 1'b0;
    logic       m_main = 1'b0;
    int         k = 0;
    logic [1:0] ps1 = '0;
    logic [1:0] ps2 = '0;
    logic [1:0] pv = '0;

    always #5 clk = ~clk;

    tmr_presc_share i_tmr_presc_share (
        .clk       (clk),
        .rst       (rst),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .clk_sel_i (clk_sel),
        .ext_pin_i (ext_pin),
        .cnt_en_o  (cnt_en),
        .aux_rst_o (aux_rst)
    );

    function automatic logic exp_en(input int ch);
        int cs;
        int n;
        cs = int'(clk_sel[ch]);
        if (m_main) return 1'b0;
        case (cs)
            0: return 1'b0;
            1: return 1'b1;
            6: return !ps2[ch] && pv[ch];
            7: return ps2[ch] && !pv[ch];
            default: begin
                n = (cs == 2) ? 8 : (cs == 3) ? 64 : (cs == 4) ? 256 : 1024;
                return (k % n) == (n - 1);
            end
        endcase
    endfunction

    function automatic string tag_for(input int ch);
        int cs;
        cs = int'(clk_sel[ch]);
        if (tag_ovr != "") return tag_ovr;
        if (m_main) return "R7";
        if (cs == 0) return "R2";
        if (cs == 1) return "R3";
        if (cs >= 6) return "R5";
        return "R4";
    endfunction

    task automatic check_val(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // one clock period: drive write, compare at mid-cycle, advance model, wait
    task automatic run_cycle(input logic wr, input logic [7:0] wd);
        logic old_main;
        reg_wr_en = wr;
        reg_wdata = wd;
        #1;
        check_val((tag_ovr != "") ? tag_ovr : "R9", "register read",
                  int'(reg_rdata), int'({m_sync, 5'b0, m_aux, m_main}));
        check_val((tag_ovr != "") ? tag_ovr : "R10", "aux restart", int'(aux_rst), int'(m_aux));
        for (int ch = 0; ch < 2; ch++) begin
            check_val(tag_for(ch), $sformatf("enable ch%0d", ch), int'(cnt_en[ch]), int'(exp_en(ch)));
        end
        if (clk_sel[0] == clk_sel[1] && clk_sel[0] != 3'd0 && clk_sel[0] < 3'd6) begin
            check_val("R11", "lockstep", int'(cnt_en[0]), int'(cnt_en[1]));
        end
        old_main = m_main;
        if (wr) begin
            m_sync = wd[7];
            m_aux  = wd[1];
            m_main = wd[0];
        end else if (!m_sync) begin
            m_aux  = 1'b0;
            m_main = 1'b0;
        end
        if (old_main) k = 0;
        else k++;
        pv  = ps2;
        ps2 = ps1;
        ps1 = ext_pin;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) run_cycle(1'b0, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        lfsr = 8'h5A;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, first div-8 tick after eight cycles
        tag_ovr = "R1";
        clk_sel[0] = 3'd2;
        clk_sel[1] = 3'd5;
        idle(10);
        tag_ovr = "";

        // R2 R3 R4 R11: sweep of every internal select pair
        for (int a = 0; a < 6; a++) begin
            for (int b = 0; b < 6; b++) begin
                clk_sel[0] = a[2:0];
                clk_sel[1] = b[2:0];
                idle(1030);
            end
        end

        // R5: external edges, both polarities, varied pin patterns
        for (int mode = 0; mode < 4; mode++) begin
            clk_sel[0] = (mode[0]) ? 3'd6 : 3'd7;
            clk_sel[1] = (mode[1]) ? 3'd6 : 3'd7;
            for (int i = 0; i < 600; i++) begin
                if (i % (mode + 3) == 0) ext_pin[0] = ~ext_pin[0];
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                ext_pin[1] = lfsr[0];
                run_cycle(1'b0, 8'h00);
            end
        end

        // R6: single restart pulse mid-run
        clk_sel[0] = 3'd2;
        clk_sel[1] = 3'd1;
        idle(13);
        tag_ovr = "R6";
        run_cycle(1'b1, 8'h01);
        idle(20);

        // R7: hold with restart latched, pins still toggling
        tag_ovr = "R7";
        clk_sel[0] = 3'd1;
        clk_sel[1] = 3'd7;
        run_cycle(1'b1, 8'h81);
        for (int i = 0; i < 40; i++) begin
            ext_pin[1] = ~ext_pin[1];
            run_cycle(1'b0, 8'h00);
        end
        tag_ovr = "R10";
        run_cycle(1'b1, 8'h83);
        idle(10);

        // R8: release, both channels restart together
        tag_ovr = "R8";
        clk_sel[0] = 3'd2;
        clk_sel[1] = 3'd2;
        run_cycle(1'b1, 8'h00);
        idle(30);
        run_cycle(1'b1, 8'h81);
        idle(5);
        run_cycle(1'b1, 8'h01);
        idle(25);

        // R9: reserved bits ignored
        tag_ovr = "R9";
        run_cycle(1'b1, 8'h7C);
        idle(12);

        // R10: auxiliary bit pulses without disturbing the divider
        tag_ovr = "R10";
        clk_sel[1] = 3'd3;
        idle(5);
        run_cycle(1'b1, 8'h02);
        idle(140);
        tag_ovr = "";

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule